// File: doc/BRIEF.md
# Global Compare Timer with Auto-Increment

This block is a memory-mapped system timer. A 64-bit counter advances by one on every clock while its run bit is set, and a single 64-bit comparator watches it. When the comparator is enabled and the counter equals the compare value, a sticky interrupt flag is raised. In one-shot use the compare value stays where software put it. In periodic use a programmed 32-bit step is added to the compare value after each match, so the next event is scheduled without software action.

Software reaches the block through a simple register bus: a write strobe with address and data, and a read path that returns the addressed register at once. Every write to a counter, compare, step or control register raises its own sticky write-status flag. Software polls that flag to confirm the write has taken effect, then clears it by writing 1. The 64-bit counter is read as two words. A coherent value comes from reading the high word, then the low word, then the high word again, and retrying if the two high reads differ.

Top module: `gct_top`

## Requirements
- R1: After reset every register reads zero: counter, compare, step, control, interrupt enable, interrupt status and both write-status registers. The interrupt output `irq` is low.
- R2: While control bit 8 (run) is set, the counter increases by one on every clock, with carry from the low word into the high word. While run is clear, the counter holds its value.
- R3: The counter low word is at offset 0x100 and the high word at 0x104. Each can be read. A write loads that word, and the load takes priority over counting.
- R4: The control register at 0x240 stores bit 8 (run), bit 1 (auto-increment) and bit 0 (comparator enable). All other bits read zero.
- R5: The compare value is at 0x200 (low word) and 0x204 (high word), and the step is at 0x208. Each reads back the value last written.
- R6: With the comparator enabled, interrupt status (bit 0 of 0x244) reads 1 from the cycle after the one in which the counter equals the compare value. With the comparator disabled, a match never sets it.
- R7: Interrupt status stays set until software writes 1 to bit 0 of 0x244. Writing 0 there has no effect. The flag sets whether or not the interrupt is enabled.
- R8: `irq` is high exactly when interrupt status is set and the interrupt enable (bit 0 of 0x248) is set.
- R9: On a match with auto-increment set, the compare value becomes compare plus step from the next cycle. With auto-increment clear, the compare value is unchanged by a match.
- R10: The write-status register at 0x24C reads bit 16 after a control write, bit 0 after a compare-low write, bit 1 after a compare-high write and bit 2 after a step write. Each bit reads 1 from the cycle after the write and clears when 1 is written to that bit.
- R11: The counter write-status register at 0x110 reads bit 0 after a counter-low write and bit 1 after a counter-high write. Each bit clears when 1 is written to it.
- R12: Reads from unmapped offsets return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, accepted on the rising edge |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| irq | output | 1 | Interrupt request: status AND enable |

## Verification
The comparator is tried with random compare values and steps against a running counter. The first interrupt must appear with the counter at exactly compare+1, and the second at compare+step+1. This separates an off-by-one in the match timing from a wrong step addition. The same match is repeated with auto-increment off, with the interrupt disabled and with the comparator disabled, to tell apart the effect of each control bit. The counter is loaded close to the 32-bit boundary and run for a random number of cycles, which exposes a missing carry or a missed hold. Random register values are written and read back with their write-status flags to check decoding and write-1-to-clear.

// File: rtl/gct_pkg.sv
// Package: shared register offsets and bit positions for the global compare timer.
// Assumes a 12-bit byte address and 32-bit data words.
package gct_pkg;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 12'h104;
    localparam logic [ADDR_W-1:0] OFS_CNT_WS = 12'h110;
    localparam logic [ADDR_W-1:0] OFS_CMP_LO = 12'h200;
    localparam logic [ADDR_W-1:0] OFS_CMP_HI = 12'h204;
    localparam logic [ADDR_W-1:0] OFS_STEP   = 12'h208;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h240;
    localparam logic [ADDR_W-1:0] OFS_ISTAT  = 12'h244;
    localparam logic [ADDR_W-1:0] OFS_IEN    = 12'h248;
    localparam logic [ADDR_W-1:0] OFS_WSTAT  = 12'h24C;

    localparam int CTRL_RUN  = 8;
    localparam int CTRL_AINC = 1;
    localparam int CTRL_CEN  = 0;

    localparam int WS_CLO  = 0;
    localparam int WS_CHI  = 1;
    localparam int WS_STEP = 2;
    localparam int WS_CTRL = 16;

    localparam int NFLAGS = 6;
    localparam int FL_CLO   = 0;
    localparam int FL_CHI   = 1;
    localparam int FL_STEP  = 2;
    localparam int FL_CTRL  = 3;
    localparam int FL_CNTLO = 4;
    localparam int FL_CNTHI = 5;

    typedef struct packed {
        logic cnt_lo;
        logic cnt_hi;
        logic cnt_ws;
        logic cmp_lo;
        logic cmp_hi;
        logic step;
        logic ctrl;
        logic istat;
        logic ien;
        logic wstat;
    } wr_sel_t;
endpackage

// File: rtl/gct_counter.sv
// Module: gct_counter
// 64-bit free-running counter built from two bus words. A word load wins over
// counting; counting happens only while run is set. Assumes synchronous active-low reset.
module gct_counter #(
    parameter int BUS_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               ld_lo,
    input  logic               ld_hi,
    input  logic [BUS_W-1:0]   wdata,
    output logic [2*BUS_W-1:0] cnt
);
    localparam int CNT_W = 2 * BUS_W;

    // Purpose: load a word from the bus, else advance when running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (ld_lo || ld_hi) begin
            if (ld_lo) cnt[BUS_W-1:0]     <= wdata;
            if (ld_hi) cnt[CNT_W-1:BUS_W] <= wdata;
        end else if (run) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ld_lo && !ld_hi) |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ld_lo && !ld_hi) |=> $stable(cnt));
endmodule

// File: rtl/gct_compare.sv
// Module: gct_compare
// Single 64-bit comparator with optional auto-advance by a 32-bit step, and
// the sticky interrupt status flag. A bus load of a compare word wins over
// auto-advance; a new match wins over a clear in the same cycle.
module gct_compare #(
    parameter int BUS_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*BUS_W-1:0] cnt,
    input  logic               cmp_en,
    input  logic               ainc,
    input  logic [BUS_W-1:0]   step,
    input  logic               ld_lo,
    input  logic               ld_hi,
    input  logic [BUS_W-1:0]   wdata,
    input  logic               clr_stat,
    output logic [2*BUS_W-1:0] cmp,
    output logic               int_stat,
    output logic               match
);
    localparam int CNT_W = 2 * BUS_W;

    // Purpose: detect equality of counter and compare value while enabled.
    always_comb begin
        match = cmp_en && (cnt == cmp);
    end

    // Purpose: hold the compare value; bus loads first, then auto-advance on match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp <= '0;
        end else if (ld_lo || ld_hi) begin
            if (ld_lo) cmp[BUS_W-1:0]     <= wdata;
            if (ld_hi) cmp[CNT_W-1:BUS_W] <= wdata;
        end else if (match && ainc) begin
            cmp <= cmp + CNT_W'(step);
        end
    end

    // Purpose: sticky interrupt status, set by a match and cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_stat <= 1'b0;
        end else if (match) begin
            int_stat <= 1'b1;
        end else if (clr_stat) begin
            int_stat <= 1'b0;
        end
    end

    // R9
    auto_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && ainc && !ld_lo && !ld_hi) |=> (cmp == $past(cmp) + CNT_W'($past(step))));

    // R9
    oneshot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !ainc && !ld_lo && !ld_hi) |=> $stable(cmp));

    // R6
    match_sets_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> int_stat);
endmodule

// File: rtl/gct_regs.sv
// Module: gct_regs
// Register bank: decodes bus writes into per-register selects, holds control,
// enable, step and the sticky write-status flags, and muxes read data.
// Assumes BUS_W of at least 17 so that the control-status bit fits.
module gct_regs
    import gct_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    input  logic [2*BUS_W-1:0] cnt,
    input  logic [2*BUS_W-1:0] cmp,
    input  logic               int_stat,
    output logic               run,
    output logic               ainc,
    output logic               cmp_en,
    output logic               int_en,
    output logic [BUS_W-1:0]   step,
    output logic               ld_cnt_lo,
    output logic               ld_cnt_hi,
    output logic               ld_cmp_lo,
    output logic               ld_cmp_hi,
    output logic               clr_stat,
    output logic [BUS_W-1:0]   bus_rdata
);
    localparam int CNT_W = 2 * BUS_W;

    wr_sel_t           sel;
    logic [NFLAGS-1:0] fl_set;
    logic [NFLAGS-1:0] fl_clr;
    logic [NFLAGS-1:0] flags;

    // Purpose: turn the write strobe and address into one select per register.
    always_comb begin
        sel = '0;
        if (bus_we) begin
            case (bus_addr)
                OFS_CNT_LO: sel.cnt_lo = 1'b1;
                OFS_CNT_HI: sel.cnt_hi = 1'b1;
                OFS_CNT_WS: sel.cnt_ws = 1'b1;
                OFS_CMP_LO: sel.cmp_lo = 1'b1;
                OFS_CMP_HI: sel.cmp_hi = 1'b1;
                OFS_STEP:   sel.step   = 1'b1;
                OFS_CTRL:   sel.ctrl   = 1'b1;
                OFS_ISTAT:  sel.istat  = 1'b1;
                OFS_IEN:    sel.ien    = 1'b1;
                OFS_WSTAT:  sel.wstat  = 1'b1;
                default:    sel        = '0;
            endcase
        end
    end

    // Purpose: export load and clear strobes to the counter and comparator.
    always_comb begin
        ld_cnt_lo = sel.cnt_lo;
        ld_cnt_hi = sel.cnt_hi;
        ld_cmp_lo = sel.cmp_lo;
        ld_cmp_hi = sel.cmp_hi;
        clr_stat  = sel.istat && bus_wdata[0];
    end

    // Purpose: control bits, interrupt enable and step register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= 1'b0;
            ainc   <= 1'b0;
            cmp_en <= 1'b0;
            int_en <= 1'b0;
            step   <= '0;
        end else begin
            if (sel.ctrl) begin
                run    <= bus_wdata[CTRL_RUN];
                ainc   <= bus_wdata[CTRL_AINC];
                cmp_en <= bus_wdata[CTRL_CEN];
            end
            if (sel.ien)  int_en <= bus_wdata[0];
            if (sel.step) step   <= bus_wdata;
        end
    end

    // Purpose: set and write-1-clear sources for each write-status flag.
    always_comb begin
        fl_set           = '0;
        fl_set[FL_CLO]   = sel.cmp_lo;
        fl_set[FL_CHI]   = sel.cmp_hi;
        fl_set[FL_STEP]  = sel.step;
        fl_set[FL_CTRL]  = sel.ctrl;
        fl_set[FL_CNTLO] = sel.cnt_lo;
        fl_set[FL_CNTHI] = sel.cnt_hi;
        fl_clr           = '0;
        fl_clr[FL_CLO]   = sel.wstat  && bus_wdata[WS_CLO];
        fl_clr[FL_CHI]   = sel.wstat  && bus_wdata[WS_CHI];
        fl_clr[FL_STEP]  = sel.wstat  && bus_wdata[WS_STEP];
        fl_clr[FL_CTRL]  = sel.wstat  && bus_wdata[WS_CTRL];
        fl_clr[FL_CNTLO] = sel.cnt_ws && bus_wdata[0];
        fl_clr[FL_CNTHI] = sel.cnt_ws && bus_wdata[1];
    end

    for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
        // Purpose: one sticky flag; a new write wins over a clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else if (fl_set[i]) begin
                flags[i] <= 1'b1;
            end else if (fl_clr[i]) begin
                flags[i] <= 1'b0;
            end
        end
    end

    // Purpose: return the addressed register; unmapped offsets read zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CNT_LO: bus_rdata = cnt[BUS_W-1:0];
            OFS_CNT_HI: bus_rdata = cnt[CNT_W-1:BUS_W];
            OFS_CNT_WS: begin
                bus_rdata[0] = flags[FL_CNTLO];
                bus_rdata[1] = flags[FL_CNTHI];
            end
            OFS_CMP_LO: bus_rdata = cmp[BUS_W-1:0];
            OFS_CMP_HI: bus_rdata = cmp[CNT_W-1:BUS_W];
            OFS_STEP:   bus_rdata = step;
            OFS_CTRL: begin
                bus_rdata[CTRL_RUN]  = run;
                bus_rdata[CTRL_AINC] = ainc;
                bus_rdata[CTRL_CEN]  = cmp_en;
            end
            OFS_ISTAT:  bus_rdata[0] = int_stat;
            OFS_IEN:    bus_rdata[0] = int_en;
            OFS_WSTAT: begin
                bus_rdata[WS_CLO]  = flags[FL_CLO];
                bus_rdata[WS_CHI]  = flags[FL_CHI];
                bus_rdata[WS_STEP] = flags[FL_STEP];
                bus_rdata[WS_CTRL] = flags[FL_CTRL];
            end
            default:    bus_rdata = '0;
        endcase
    end

    // R10
    ctrl_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel.ctrl |=> flags[FL_CTRL]);

    // R10
    ctrl_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel.wstat && bus_wdata[WS_CTRL] && !sel.ctrl) |=> !flags[FL_CTRL]);

    // R11
    cnt_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel.cnt_lo || sel.cnt_hi) |=> (flags[FL_CNTLO] || flags[FL_CNTHI]));
endmodule

// File: rtl/gct_top.sv
// Module: gct_top
// Global compare timer: register bank, 64-bit counter and one comparator with
// auto-advance. The interrupt request is the status flag gated by its enable.
module gct_top #(
    parameter int BUS_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_we,
    input  logic [gct_pkg::ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]           bus_wdata,
    output logic [BUS_W-1:0]           bus_rdata,
    output logic                       irq
);
    localparam int CNT_W = 2 * BUS_W;

    logic               run, ainc, cmp_en, int_en;
    logic [BUS_W-1:0]   step;
    logic               ld_cnt_lo, ld_cnt_hi, ld_cmp_lo, ld_cmp_hi, clr_stat;
    logic [CNT_W-1:0]   cnt, cmp;
    logic               int_stat, match;

    gct_regs #(.BUS_W(BUS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .cnt(cnt), .cmp(cmp), .int_stat(int_stat),
        .run(run), .ainc(ainc), .cmp_en(cmp_en), .int_en(int_en), .step(step),
        .ld_cnt_lo(ld_cnt_lo), .ld_cnt_hi(ld_cnt_hi),
        .ld_cmp_lo(ld_cmp_lo), .ld_cmp_hi(ld_cmp_hi),
        .clr_stat(clr_stat), .bus_rdata(bus_rdata)
    );

    gct_counter #(.BUS_W(BUS_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .ld_lo(ld_cnt_lo),
        .ld_hi(ld_cnt_hi), .wdata(bus_wdata), .cnt(cnt)
    );

    gct_compare #(.BUS_W(BUS_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .cmp_en(cmp_en), .ainc(ainc),
        .step(step), .ld_lo(ld_cmp_lo), .ld_hi(ld_cmp_hi), .wdata(bus_wdata),
        .clr_stat(clr_stat), .cmp(cmp), .int_stat(int_stat), .match(match)
    );

    // Purpose: gate the sticky status with the interrupt enable.
    always_comb begin
        irq = int_stat && int_en;
    end

    // R6
    no_match_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_en && !int_stat && !(bus_we && bus_addr == gct_pkg::OFS_CTRL)) |=> !int_stat);
endmodule

// File: tb/sim_gct_top.sv
module sim_gct_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    localparam logic [11:0] A_CLO = 12'h100, A_CHI = 12'h104, A_CWS = 12'h110;
    localparam logic [11:0] A_MLO = 12'h200, A_MHI = 12'h204, A_STP = 12'h208;
    localparam logic [11:0] A_CTL = 12'h240, A_IST = 12'h244, A_IEN = 12'h248;
    localparam logic [11:0] A_WST = 12'h24C;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    gct_top u0 (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
                .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

    always #10 clk = ~clk;

    function automatic logic [63:0] expect_sum(logic [63:0] a, logic [63:0] b);
        return a + b;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic cycle();
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, h;
        logic [63:0] x;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset values
        begin
            logic [11:0] all [10] = '{A_CLO, A_CHI, A_CWS, A_MLO, A_MHI, A_STP, A_CTL, A_IST, A_IEN, A_WST};
            foreach (all[i]) begin rd(all[i], v); check("R1 reg", v, 0); end
        end
        check("R1 irq", irq, 0);

        // R4 control keeps only its three bits
        wr(A_CTL, 32'hFFFF_FEFE); rd(A_CTL, v); check("R4 ctrl", v, 32'h0000_0002);
        wr(A_CTL, 32'h0); wr(A_WST, 32'h0001_0000);

        // R5 R3 R10 R11 random writes, read-back, ack flags, W1C
        for (int it = 0; it < 8; it++) begin
            logic [31:0] r [5];
            logic [11:0] ad [5] = '{A_MLO, A_MHI, A_STP, A_CLO, A_CHI};
            foreach (r[i]) r[i] = $urandom;
            foreach (ad[i]) wr(ad[i], r[i]);
            for (int i = 0; i < 3; i++) begin rd(ad[i], v); check("R5 readback", v, r[i]); end
            for (int i = 3; i < 5; i++) begin rd(ad[i], v); check("R3 readback", v, r[i]); end
            rd(A_WST, v); check("R10 ack set", v, 32'h0000_0007);
            rd(A_CWS, v); check("R11 ack set", v, 32'h3);
            wr(A_WST, 32'h2); rd(A_WST, v); check("R10 partial clear", v, 32'h5);
            wr(A_WST, 32'h5); rd(A_WST, v); check("R10 clear", v, 0);
            wr(A_CWS, 32'h1); rd(A_CWS, v); check("R11 partial clear", v, 32'h2);
            wr(A_CWS, 32'h2); rd(A_CWS, v); check("R11 clear", v, 0);
        end
        wr(A_CTL, 32'h0); rd(A_WST, v); check("R10 ctrl ack", v, 32'h0001_0000);
        wr(A_WST, 32'h0001_0000); rd(A_WST, v); check("R10 ctrl clear", v, 0);

        // R12 unmapped offsets
        wr(A_STP, 32'h1234_5678); wr(A_WST, 32'h4);
        wr(12'h0FC, 32'hFFFF_FFFF); rd(12'h0FC, v); check("R12 read zero", v, 0);
        wr(12'h24D, 32'hFFFF_FFFF); rd(A_STP, v); check("R12 step intact", v, 32'h1234_5678);
        rd(A_WST, v); check("R12 no ack", v, 0);
        rd(A_CTL, v); check("R12 ctrl intact", v, 0);

        // R2 counting with carry, then hold
        begin
            int k = 20 + int'($urandom % 20);
            wr(A_CLO, 32'hFFFF_FFF0); wr(A_CHI, 32'h5);
            wr(A_CTL, 32'h100);
            repeat (k) cycle();
            wr(A_CTL, 32'h0);
            x = expect_sum({32'h5, 32'hFFFF_FFF0}, 64'(k + 1));
            rd(A_CHI, h); rd(A_CLO, v); check("R2 count", {h, v}, x);
            repeat (7) cycle();
            rd(A_CHI, h); rd(A_CLO, v); check("R2 hold", {h, v}, x);
        end

        // R6 R8 R9 periodic matches with random compare and step
        for (int it = 0; it < 3; it++) begin
            int c = 20 + int'($urandom % 40);
            int s = 30 + int'($urandom % 50);
            bit seen;
            wr(A_CTL, 32'h0); wr(A_IST, 32'h1);
            wr(A_CLO, 0); wr(A_CHI, 0); wr(A_MLO, c); wr(A_MHI, 0);
            wr(A_STP, s); wr(A_IEN, 1);
            wr(A_CTL, 32'h103);
            seen = 0;
            for (int j = 0; j < 400 && !seen; j++) begin
                cycle(); if (irq) seen = 1;
            end
            rd(A_CLO, v); check("R6 first match time", v, c + 1);
            rd(A_MLO, v); check("R9 advance", v, expect_sum(c, s));
            wr(A_IST, 32'h1); rd(A_IST, v); check("R7 clear", v, 0);
            check("R8 irq low", irq, 0);
            seen = 0;
            for (int j = 0; j < 400 && !seen; j++) begin
                cycle(); if (irq) seen = 1;
            end
            rd(A_CLO, v); check("R9 second match time", v, c + s + 1);
            rd(A_MLO, v); check("R9 advance twice", v, c + 2 * s);
        end

        // R9 one-shot, R7 sticky, R8 enable gating
        begin
            bit seen = 0;
            wr(A_CTL, 32'h0); wr(A_IST, 32'h1); wr(A_IEN, 0);
            wr(A_CLO, 0); wr(A_CHI, 0); wr(A_MLO, 15); wr(A_MHI, 0);
            wr(A_CTL, 32'h101);
            for (int j = 0; j < 100 && !seen; j++) begin
                cycle(); rd(A_IST, v); if (v[0]) seen = 1;
            end
            rd(A_CLO, v); check("R6 oneshot match time", v, 16);
            check("R8 masked irq", irq, 0);
            rd(A_MLO, v); check("R9 oneshot unchanged", v, 15);
            wr(A_IEN, 1); check("R8 irq when enabled", irq, 1);
            wr(A_IST, 32'h0); rd(A_IST, v); check("R7 write zero no effect", v, 1);
            wr(A_IST, 32'h1); rd(A_IST, v); check("R7 clear by one", v, 0);
            check("R8 irq drops", irq, 0);
        end

        // R6 comparator disabled: no match
        wr(A_CTL, 32'h0); wr(A_CLO, 0); wr(A_MLO, 10); wr(A_CTL, 32'h100);
        repeat (30) cycle();
        rd(A_IST, v); check("R6 disabled no status", v, 0);
        check("R6 disabled no irq", irq, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule